// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static memory with two byte lanes of nine bits each. All controls and the address are captured on the rising clock edge. An access is opened by one of two low-active address strobes. The processor-side strobe always opens a read and is gated by the main chip enable. The controller-side strobe yields to the processor strobe and samples the write enables to choose between read and write. Once an access is open, an advance input walks the two low address bits through a four-beat burst. The order is either interleaved (XOR of the start bits with the beat count) or linear (addition modulo four).

Reads are pipelined. The address is registered on one edge and the word appears on the data-out port after the following edge. The tri-state data bus is modelled as a data-out vector plus a drive-enable flag. Write data is taken on the same edge that samples the lane enables.

Top module: `burst_sram`

## Requirements
- R1: When the processor strobe is low and the main chip enable is low on an edge, a read opens at the presented address, whatever the write enables and the controller strobe are doing.
- R2: The controller strobe opens an access only on an edge where the processor strobe does not open one. On that edge the write enables choose between write and read.
- R3: With the main chip enable high, a low processor strobe opens nothing. With the main chip enable high and the controller strobe low, the block deselects: the open burst ends and no access occurs.
- R4: Chip enable `chipEnHi` is active high and `chipEnLoN` is active low. If either is inactive on an opening edge, the block deselects and neither reads nor writes.
- R5: Advance is ignored on the edge that opens an access. On later edges with no opening and no deselect, advance low moves to the next burst beat and advance high repeats the current address (suspend).
- R6: With `burstXor` high, the low two address bits of beat n are the start bits XOR n. With it low, they are (start bits + n) mod 4. The upper address bits never change within a burst.
- R7: Global write enable low writes both lanes. Otherwise, byte-write enable low writes exactly the lanes whose `laneWrN` bit is low. Lane 0 is `wrData[8:0]` and lane 1 is `wrData[17:9]`. Any other combination is a read. The lane enables are also sampled on each burst-continuation edge.
- R8: A read address registered on edge k is presented on `rdData` after edge k+1. `rdDrive` is high only while `outEnN` is low and read data is valid; `outEnN` acts without a clock.
- R9: After an edge that samples any write, `rdDrive` is low. After a deselect edge, `rdDrive` is low no later than the following edge.
- R10: During and directly after reset, no burst is open and `rdDrive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addrIn | input | ADDR_W | Word address presented with a strobe |
| procStrobeN | input | 1 | Processor-side address strobe, low active, read only |
| ctrlStrobeN | input | 1 | Controller-side address strobe, low active |
| advanceN | input | 1 | Burst advance, low steps the beat |
| chipEnMainN | input | 1 | Main chip enable, low active |
| chipEnHi | input | 1 | Secondary chip enable, high active |
| chipEnLoN | input | 1 | Secondary chip enable, low active |
| globalWrN | input | 1 | Write-all-lanes enable, low active |
| byteWrN | input | 1 | Qualifier for per-lane enables, low active |
| laneWrN | input | LANES | Per-lane write enables, low active |
| burstXor | input | 1 | Burst order: 1 interleaved, 0 linear |
| outEnN | input | 1 | Output enable, low active, unclocked |
| wrData | input | LANES*LANE_W | Write data |
| rdData | output | LANES*LANE_W | Output register contents |
| rdDrive | output | 1 | High when the data bus would be driven |

## Verification
On every cycle, the assertions check how the strobes and enables decide the access: a processor-strobe read never carries lane writes, the controller-strobe write opens at the presented address, blocked or partially selected openings do nothing, and the address holds on suspend while its upper bits stay fixed during a burst. They also check that the drive flag falls after writes and deselects and never rises while the output enable is off. What data actually comes back, so burst order, wrap-around, partial-lane merging and the one-cycle read pipeline, can only be shown by the bench scenarios. There, a behavioural memory model is compared against the outputs.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // strobes from control to datapath for the current edge
  typedef struct packed {
    logic accValid;   // an access (read or write) happens on this edge
    logic wrAny;      // at least one lane is written on this edge
  } dpCtl_t;

  // low two address bits of a burst beat
  function automatic logic [1:0] burstLow(input logic [1:0] startLow,
                                          input logic [1:0] beat,
                                          input logic       xorOrder);
    return xorOrder ? (startLow ^ beat) : (startLow + beat);
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              chipEnMainN,
  input  logic              chipEnHi,
  input  logic              chipEnLoN,
  input  logic              globalWrN,
  input  logic              byteWrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstXor,
  output dpCtl_t            dpCtl,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  laneWe
);

  localparam int HI_W = ADDR_W - 2;

  logic              burstOpen;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        beatCnt;
  logic [1:0]        beatNext;
  logic              procGo;
  logic              ctrlGo;
  logic              selectOk;
  logic [LANES-1:0]  decodedLanes;
  logic [HI_W-1:0]   baseHigh;

  assign baseHigh = baseAddr[ADDR_W-1:2];

  always_comb begin
    procGo   = !procStrobeN && !chipEnMainN;
    ctrlGo   = !procGo && !ctrlStrobeN;
    selectOk = !chipEnMainN && chipEnHi && !chipEnLoN;

    if (!globalWrN)    decodedLanes = '1;
    else if (!byteWrN) decodedLanes = ~laneWrN;
    else               decodedLanes = '0;

    beatNext = advanceN ? beatCnt : beatCnt + 2'd1;

    dpCtl.accValid = 1'b0;
    laneWe         = '0;
    accAddr        = addrIn;
    if (procGo || ctrlGo) begin
      if (selectOk) begin
        dpCtl.accValid = 1'b1;
        laneWe         = ctrlGo ? decodedLanes : '0;
      end
    end else if (burstOpen) begin
      dpCtl.accValid = 1'b1;
      laneWe         = decodedLanes;
      accAddr        = {baseHigh, burstLow(baseAddr[1:0], beatNext, burstXor)};
    end
    dpCtl.wrAny = |laneWe;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burstOpen <= 1'b0;
      baseAddr  <= '0;
      beatCnt   <= 2'd0;
    end else if (procGo || ctrlGo) begin
      burstOpen <= selectOk;
      baseAddr  <= addrIn;
      beatCnt   <= 2'd0;
    end else if (burstOpen) begin
      beatCnt   <= beatNext;
    end
  end

endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dpCtl_t                  dpCtl,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [LANES-1:0]        laneWe,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);

  localparam int DEPTH = 1 << ADDR_W;

  logic              rdPendQ;
  logic [ADDR_W-1:0] rdAddrQ;
  logic              outValidQ;

  // stage 1 holds the read address, stage 2 the output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPendQ   <= 1'b0;
      rdAddrQ   <= '0;
      outValidQ <= 1'b0;
    end else begin
      rdPendQ   <= dpCtl.accValid && !dpCtl.wrAny;
      rdAddrQ   <= accAddr;
      outValidQ <= rdPendQ && !dpCtl.wrAny;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneOutQ;

    always_ff @(posedge clk) begin
      if (laneWe[g]) laneMem[accAddr] <= wrData[g*LANE_W +: LANE_W];
      if (rdPendQ)   laneOutQ <= laneMem[rdAddrQ];
    end

    assign rdData[g*LANE_W +: LANE_W] = laneOutQ;
  end

  assign rdDrive = outValidQ && !outEnN;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    advanceN,
  input  logic                    chipEnMainN,
  input  logic                    chipEnHi,
  input  logic                    chipEnLoN,
  input  logic                    globalWrN,
  input  logic                    byteWrN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    burstXor,
  input  logic                    outEnN,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);

  dpCtl_t            ctrlToDp;
  logic [ADDR_W-1:0] accAddr;
  logic [LANES-1:0]  laneWe;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .chipEnMainN(chipEnMainN), .chipEnHi(chipEnHi), .chipEnLoN(chipEnLoN),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .laneWrN(laneWrN),
    .burstXor(burstXor), .dpCtl(ctrlToDp), .accAddr(accAddr), .laneWe(laneWe)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtl(ctrlToDp), .accAddr(accAddr),
    .laneWe(laneWe), .wrData(wrData), .outEnN(outEnN),
    .rdData(rdData), .rdDrive(rdDrive)
  );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addrIn,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              chipEnMainN,
  input logic              chipEnHi,
  input logic              chipEnLoN,
  input logic              globalWrN,
  input logic              outEnN,
  input logic              rdDrive,
  input dpCtl_t            strb,
  input logic [ADDR_W-1:0] accAddr,
  input logic [LANES-1:0]  laneWe
);

  a_r1_proc_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!procStrobeN && !chipEnMainN) |-> (laneWe == '0));

  a_r2_ctrl_write_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (procStrobeN && !ctrlStrobeN && !chipEnMainN && chipEnHi && !chipEnLoN && !globalWrN)
      |-> (laneWe == '1 && accAddr == addrIn && strb.accValid));

  a_r3_main_off_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlStrobeN && chipEnMainN) |-> (!strb.accValid && laneWe == '0));

  a_r4_partial_select_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!procStrobeN && !chipEnMainN && (!chipEnHi || chipEnLoN)) |-> (!strb.accValid && laneWe == '0));

  a_r5_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (procStrobeN && ctrlStrobeN && advanceN && $past(strb.accValid))
      |-> (strb.accValid && accAddr == $past(accAddr)));

  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (procStrobeN && ctrlStrobeN && $past(strb.accValid))
      |-> (accAddr[ADDR_W-1:2] == $past(accAddr[ADDR_W-1:2])));

  a_r8_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rdDrive |-> !outEnN);

  a_r9_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (laneWe != '0) |=> !rdDrive);

  a_r9_deselect_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlStrobeN && chipEnMainN) |=> ##1 !rdDrive);

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .addrIn(addrIn),
  .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
  .chipEnMainN(chipEnMainN), .chipEnHi(chipEnHi), .chipEnLoN(chipEnLoN),
  .globalWrN(globalWrN), .outEnN(outEnN), .rdDrive(rdDrive),
  .strb(ctrlToDp), .accAddr(accAddr), .laneWe(laneWe)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addrIn = '0;
  logic        procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic        chipEnMainN = 1'b0, chipEnHi = 1'b1, chipEnLoN = 1'b0;
  logic        globalWrN = 1'b1, byteWrN = 1'b1;
  logic [1:0]  laneWrN = 2'b11;
  logic        burstXor = 1'b0, outEnN = 1'b0;
  logic [17:0] wrData = '0;
  logic [17:0] rdData;
  logic        rdDrive;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .chipEnMainN(chipEnMainN),
    .chipEnHi(chipEnHi), .chipEnLoN(chipEnLoN), .globalWrN(globalWrN),
    .byteWrN(byteWrN), .laneWrN(laneWrN), .burstXor(burstXor), .outEnN(outEnN),
    .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive)
  );

  function automatic logic [17:0] pat(input int a);
    return 18'((a * 7919 + 3) ^ 'h15A5A);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [17:0] mMem [64];
  int  mOpen = 0, mStart = 0, mBeat = 0, mPendAddr = 0;
  bit  mPend = 0, mOutValid = 0;
  logic [17:0] mData = '0;
  int  mLanes, mAddr, mLow;
  bit  mAcc, mPGo, mCGo, mSel, mNextValid;
  logic [17:0] mRd;

  always @(posedge clk) begin
    if (!rst_n) begin
      mOpen = 0; mPend = 0; mOutValid = 0;
    end else begin
      mRd = mMem[mPendAddr];
      mNextValid = mPend;
      mPGo = !procStrobeN && !chipEnMainN;
      mCGo = !mPGo && !ctrlStrobeN;
      mSel = !chipEnMainN && chipEnHi && !chipEnLoN;
      mLanes = !globalWrN ? 3 : (!byteWrN ? (~int'(laneWrN) & 3) : 0);
      mAcc = 0;
      mAddr = int'(addrIn);
      if (mPGo || mCGo) begin
        mOpen = mSel; mStart = int'(addrIn); mBeat = 0;
        if (mSel) begin
          mAcc = 1;
          if (mPGo) mLanes = 0;
        end else mLanes = 0;
      end else if (mOpen != 0) begin
        if (!advanceN) mBeat = (mBeat + 1) % 4;
        mLow = burstXor ? ((mStart & 3) ^ mBeat) : (((mStart & 3) + mBeat) % 4);
        mAddr = (mStart & ~3) | mLow;
        mAcc = 1;
      end else mLanes = 0;
      if (mLanes[0]) mMem[mAddr][8:0]  = wrData[8:0];
      if (mLanes[1]) mMem[mAddr][17:9] = wrData[17:9];
      if (mNextValid) mData = mRd;
      mOutValid = mNextValid && (mLanes == 0);
      mPend = mAcc && (mLanes == 0);
      mPendAddr = mAddr;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      chk(rdDrive === (!outEnN && mOutValid), "R8 R9 drive vs model", 18'(rdDrive), 18'(!outEnN && mOutValid));
      if (rdDrive === 1'b1 && mOutValid)
        chk(rdData === mData, "R6 R7 R8 data vs model", rdData, mData);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idleIn();
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1;
    chipEnMainN = 0; chipEnHi = 1; chipEnLoN = 0;
    globalWrN = 1; byteWrN = 1; laneWrN = 2'b11; wrData = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // processor-strobe read with write enables and controller strobe also low
  task automatic openProcRead(input int a);
    idleIn();
    addrIn = 6'(a); procStrobeN = 0; ctrlStrobeN = 0; globalWrN = 0;
    advanceN = 0; wrData = '1;
  endtask

  task automatic burstRd(input int a, input bit ord, input int e0, input int e1,
                         input int e2, input int e3, input string tag);
    burstXor = ord;
    openProcRead(a);
    step();
    idleIn(); advanceN = 0;
    step(); chk(rdDrive === 1'b1 && rdData === pat(e0), tag, rdData, pat(e0));
    step(); chk(rdData === pat(e1), tag, rdData, pat(e1));
    step(); chk(rdData === pat(e2), tag, rdData, pat(e2));
    advanceN = 1;
    step(); chk(rdData === pat(e3), tag, rdData, pat(e3));
    step(); chk(rdData === pat(e3), {tag, " R5 suspend"}, rdData, pat(e3));
  endtask

  task automatic rdOne(input int a, input logic [17:0] exp, input string tag);
    openProcRead(a);
    step();
    idleIn();
    step();
    chk(rdDrive === 1'b1 && rdData === exp, tag, rdData, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 18'd0, 18'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    idleIn();
    repeat (3) step();
    chk(rdDrive === 1'b0, "R10 reset drive", 18'(rdDrive), 18'd0);
    rst_n = 1;
    step();
    chk(rdDrive === 1'b0, "R10 after reset", 18'(rdDrive), 18'd0);

    // fill all words with linear controller-strobe write bursts (R2, R7)
    burstXor = 0;
    for (int b = 0; b < 64; b += 4) begin
      idleIn(); addrIn = 6'(b); ctrlStrobeN = 0; globalWrN = 0; wrData = pat(b);
      step();
      for (int i = 1; i < 4; i++) begin
        idleIn(); advanceN = 0; globalWrN = 0; wrData = pat(b + i);
        step();
        chk(rdDrive === 1'b0, "R9 write burst floats", 18'(rdDrive), 18'd0);
      end
    end

    // R1 R5: strobe-open read ignores write enables and advance
    burstRd(8, 0, 8, 9, 10, 11, "R1 R5 R8 linear burst");
    // R6 orders, including wrap and fixed upper bits
    burstRd(37, 1, 37, 36, 39, 38, "R6 interleaved");
    burstRd(37, 0, 37, 38, 39, 36, "R6 linear wrap");
    burstRd(58, 1, 58, 59, 56, 57, "R6 interleaved start 2");

    // R2 R7: controller strobe with only byte enables high is a read
    idleIn(); addrIn = 6'd51; ctrlStrobeN = 0; laneWrN = 2'b00;
    step(); idleIn(); step();
    chk(rdDrive === 1'b1 && rdData === pat(51), "R2 R7 read when byte enable high", rdData, pat(51));

    // R7 lane 0 only
    idleIn(); addrIn = 6'd50; ctrlStrobeN = 0; byteWrN = 0; laneWrN = 2'b10; wrData = '1;
    step(); idleIn(); step();
    rdOne(50, {pat(50)[17:9], 9'h1FF}, "R7 lane0 only");

    // R7 lane 1 on start and on a continuation beat
    idleIn(); addrIn = 6'd44; ctrlStrobeN = 0; byteWrN = 0; laneWrN = 2'b01; wrData = '1;
    step();
    idleIn(); advanceN = 0; byteWrN = 0; laneWrN = 2'b01; wrData = '1;
    step(); idleIn(); step();
    rdOne(44, {9'h1FF, pat(44)[8:0]}, "R7 lane1 start");
    rdOne(45, {9'h1FF, pat(45)[8:0]}, "R7 lane1 continuation");

    // R3 deselect through controller strobe with main enable off
    openProcRead(40); step();
    idleIn(); ctrlStrobeN = 0; chipEnMainN = 1; step();
    chk(rdDrive === 1'b1 && rdData === pat(40), "R3 data before deselect", rdData, pat(40));
    idleIn(); step();
    chk(rdDrive === 1'b0, "R3 R9 deselect floats", 18'(rdDrive), 18'd0);
    // R3 blocked processor strobe opens nothing while idle
    idleIn(); addrIn = 6'd20; procStrobeN = 0; chipEnMainN = 1; step();
    idleIn(); step();
    chk(rdDrive === 1'b0, "R3 blocked strobe", 18'(rdDrive), 18'd0);
    // R3 blocked processor strobe during a burst continues it
    openProcRead(24); step();
    idleIn(); procStrobeN = 0; chipEnMainN = 1; advanceN = 0; step();
    chk(rdData === pat(24), "R3 burst first beat", rdData, pat(24));
    idleIn(); step();
    chk(rdDrive === 1'b1 && rdData === pat(25), "R3 blocked strobe continues", rdData, pat(25));

    // R4 secondary enables
    idleIn(); addrIn = 6'd12; ctrlStrobeN = 0; globalWrN = 0; chipEnHi = 0; wrData = '0;
    step(); idleIn(); step();
    chk(rdDrive === 1'b0, "R4 deselected write", 18'(rdDrive), 18'd0);
    rdOne(12, pat(12), "R4 no write when high enable off");
    openProcRead(13); chipEnLoN = 1; step();
    idleIn(); step();
    chk(rdDrive === 1'b0, "R4 no read when low enable off", 18'(rdDrive), 18'd0);

    // R8 output enable acts without a clock
    openProcRead(16); step();
    idleIn(); outEnN = 1; step();
    chk(rdDrive === 1'b0, "R8 oe off", 18'(rdDrive), 18'd0);
    outEnN = 0; #1;
    chk(rdDrive === 1'b1 && rdData === pat(16), "R8 oe on", rdData, pat(16));

    // R9 write inside a read burst floats the bus
    step();
    openProcRead(60); step();
    idleIn(); advanceN = 0; step();
    chk(rdDrive === 1'b1 && rdData === pat(60), "R9 read before write", rdData, pat(60));
    idleIn(); advanceN = 0; globalWrN = 0; wrData = 18'h00F0F; step();
    chk(rdDrive === 1'b0, "R9 write floats", 18'(rdDrive), 18'd0);
    idleIn(); step(); step();
    rdOne(62, 18'h00F0F, "R9 R7 burst write landed");

    idleIn();
    repeat (3) step();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule